// File: doc/BRIEF.md
# Complementary Gate Timing Generator with Dead Time

This block turns a digital on-time command into two complementary gate-enable levels for a synchronous step-down power stage: one for the upper (high-side) switch and one for the lower (low-side) switch. A period counter divides the system clock down to a fixed 300 kHz switching rate. Each period the block opens an upper-gate window and then a lower-gate window. A fixed number of idle clocks sits between the fall of one gate and the rise of the other, in both directions. A supervisory sequencer enables the stage. A separate force-off input shuts both gates down at once.

The duty command is a count of system-clock cycles of high-side on-command per period. It is limited to 90 percent of the period. The block loads it only at the boundary between periods, so a command change in mid-period can never cut or stretch a pulse. A one-clock tick marks the start of every period and keeps running while the gates are held off, so other blocks can use it as their switching-rate timebase.

All three outputs are registered. The value seen on the outputs during a clock reflects the period phase of the clock before it. At the default 200 MHz clock the period is 666 cycles and the gap is 4 cycles (20 ns).

Top module: `pwm_gate_gen`

## Requirements
- R1: `period_tick` is high for exactly one clock out of every 666 (CLK_HZ/FSW_HZ). With phase p counting 0..665 from reset release, the tick shows the decode of phase 0 one clock after that phase. It keeps running while the gates are disabled.
- R2: A duty command above 599 (90 percent of 666, rounded down) acts as 599. With a clamped command the upper gate is never high for more than 599 − 4 = 595 consecutive clocks.
- R3: `gate_hi` and `gate_lo` are never both high in the same clock.
- R4: Each gate rises only after the other gate has been low for at least 4 (DEAD_CYC) clocks. This applies to both transitions.
- R5: While `enable` is low or `force_off` is high at a clock edge, both gates are low after that edge. The period counter and the duty loading continue during this time.
- R6: The duty command is loaded only at the edge where the phase is 665. A change at any other time has no effect until the next period.
- R7: With a loaded duty of 0, `gate_hi` stays low for the whole period, and `gate_lo` is high for every phase except phases 0..3.
- R8: For a loaded duty D, the outputs follow phase p one clock later: `gate_hi` is high for 4 ≤ p < D, and `gate_lo` is high for D + 4 ≤ p ≤ 665. A duty of 4 or less therefore gives no upper pulse.
- R9: While `rst_n` is low, all outputs are low. After reset release, phase 0 is the first phase counted, and the loaded duty is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (200 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_cmd | input | DUTY_W (10) | Upper-gate on-command in clock cycles per period |
| enable | input | 1 | Run permission from the supervisory sequencer |
| force_off | input | 1 | Immediate shutdown request, active high |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |
| period_tick | output | 1 | One-clock strobe at the start of each switching period |

## Verification
Two events can fall in the same clock. In the first, a shutdown or re-enable lands on the last phase of a period, which is also the clock where a new duty command is loaded and the next tick is decoded. In the second, a mid-period duty change lands on the clock where the upper window would otherwise close. The bench produces both on purpose. It waits for phase 665, then raises `force_off` and writes a new command in that same clock. It later drops `force_off` in the middle of a period and sweeps duty changes across window edges at random. Each clock, the bench compares all three outputs against its own phase-and-duty model. The model must show the new duty loaded, the tick present and both gates low, with the dead-time gap measured at every gate rise.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;

  // Limit a requested on-time to the ceiling allowed per period.
  function automatic int unsigned duty_limit(input int unsigned cmd, input int unsigned ceiling);
    return (cmd > ceiling) ? ceiling : cmd;
  endfunction

  // Upper window: opens one dead gap after the period start, closes at the duty count.
  function automatic logic hi_window(input int unsigned ph, input int unsigned duty,
                                     input int unsigned gap);
    return (ph >= gap) && (ph < duty);
  endfunction

  // Lower window: opens one dead gap after the upper window closes, runs to period end.
  function automatic logic lo_window(input int unsigned ph, input int unsigned duty,
                                     input int unsigned gap);
    return ph >= (duty + gap);
  endfunction

endpackage

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
  parameter int PERIOD = 666,
  localparam int CW = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] phase,
  output logic          at_last,
  output logic          at_first
);
  assign at_last  = (phase == CW'(PERIOD - 1));
  assign at_first = (phase == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (at_last) phase <= '0;
    else              phase <= phase + CW'(1);
  end
endmodule

// File: rtl/pwm_duty_hold.sv
module pwm_duty_hold
  import pwm_gate_pkg::*;
#(
  parameter int DUTY_W   = 10,
  parameter int DUTY_MAX = 599
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DUTY_W-1:0] cmd,
  output logic [DUTY_W-1:0] duty_q
);
  logic [DUTY_W-1:0] cmd_lim;
  assign cmd_lim = DUTY_W'(duty_limit(32'(cmd), DUTY_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    duty_q <= '0;
    else if (load) duty_q <= cmd_lim;
  end
endmodule

// File: rtl/pwm_gate_stage.sv
module pwm_gate_stage
  import pwm_gate_pkg::*;
#(
  parameter int CW       = 10,
  parameter int DUTY_W   = 10,
  parameter int DEAD_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     phase,
  input  logic [DUTY_W-1:0] duty,
  input  logic              first,
  input  logic              run,
  output logic              hi_q,
  output logic              lo_q,
  output logic              tick_q
);
  logic hi_open, lo_open;
  assign hi_open = hi_window(32'(phase), 32'(duty), DEAD_CYC);
  assign lo_open = lo_window(32'(phase), 32'(duty), DEAD_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      hi_q   <= run & hi_open;
      lo_q   <= run & lo_open;
      tick_q <= first;
    end
  end
endmodule

// File: rtl/pwm_gate_gen.sv
module pwm_gate_gen #(
  parameter int CLK_HZ   = 200_000_000,
  parameter int FSW_HZ   = 300_000,
  parameter int MAX_PCT  = 90,
  parameter int DEAD_CYC = 4,
  parameter int DUTY_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty_cmd,
  input  logic              enable,
  input  logic              force_off,
  output logic              gate_hi,
  output logic              gate_lo,
  output logic              period_tick
);
  localparam int PERIOD   = CLK_HZ / FSW_HZ;
  localparam int CW       = $clog2(PERIOD);
  localparam int DUTY_MAX = (PERIOD * MAX_PCT) / 100;

  // Named internal events, visible to the bound checker.
  logic          run;
  logic          load_duty;
  logic          start_phase;
  logic [CW-1:0] phase;
  logic [DUTY_W-1:0] duty_live;

  assign run = enable & ~force_off;

  pwm_period_ctr #(.PERIOD(PERIOD)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .at_last  (load_duty),
    .at_first (start_phase)
  );

  pwm_duty_hold #(.DUTY_W(DUTY_W), .DUTY_MAX(DUTY_MAX)) u_duty (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load_duty),
    .cmd    (duty_cmd),
    .duty_q (duty_live)
  );

  pwm_gate_stage #(.CW(CW), .DUTY_W(DUTY_W), .DEAD_CYC(DEAD_CYC)) u_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase  (phase),
    .duty   (duty_live),
    .first  (start_phase),
    .run    (run),
    .hi_q   (gate_hi),
    .lo_q   (gate_lo),
    .tick_q (period_tick)
  );
endmodule

// File: rtl/pwm_gate_chk.sv
module pwm_gate_chk #(
  parameter int DEAD_CYC = 4,
  parameter int HI_MAX   = 595
) (
  input logic clk,
  input logic rst_n,
  input logic gate_hi,
  input logic gate_lo,
  input logic period_tick,
  input logic run
);
  logic [15:0] hi_quiet, lo_quiet, hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_quiet <= '0;
      lo_quiet <= '0;
      hi_len   <= '0;
    end else begin
      if (gate_hi) hi_quiet <= '0;
      else if (32'(hi_quiet) < DEAD_CYC) hi_quiet <= hi_quiet + 16'd1;
      if (gate_lo) lo_quiet <= '0;
      else if (32'(lo_quiet) < DEAD_CYC) lo_quiet <= lo_quiet + 16'd1;
      if (!gate_hi) hi_len <= '0;
      else if (hi_len != 16'hFFFF) hi_len <= hi_len + 16'd1;
    end
  end

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  assert_hi_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> (32'(lo_quiet) >= DEAD_CYC));

  assert_lo_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo) |-> (32'(hi_quiet) >= DEAD_CYC));

  assert_idle_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!gate_hi && !gate_lo));

  assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    period_tick |=> !period_tick);

  assert_hi_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gate_hi |-> (32'(hi_len) < HI_MAX));
endmodule

bind pwm_gate_gen pwm_gate_chk #(
  .DEAD_CYC (DEAD_CYC),
  .HI_MAX   (DUTY_MAX - DEAD_CYC)
) u_gate_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gate_hi     (gate_hi),
  .gate_lo     (gate_lo),
  .period_tick (period_tick),
  .run         (run)
);

// File: tb/tb_pwm_gate_gen.sv
`timescale 1ns/1ps
module tb_pwm_gate_gen;
  localparam int P    = 666;
  localparam int DT   = 4;
  localparam int DMAX = 599;
  localparam int DW   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] duty_cmd = '0;
  logic enable = 1'b0;
  logic force_off = 1'b0;
  wire gate_hi, gate_lo, period_tick;

  always #2.5 clk = ~clk;

  pwm_gate_gen dut (
    .clk(clk), .rst_n(rst_n), .duty_cmd(duty_cmd), .enable(enable),
    .force_off(force_off), .gate_hi(gate_hi), .gate_lo(gate_lo),
    .period_tick(period_tick)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  int m_cnt = 0, m_duty = 0, lo_quiet = 0, hi_quiet = 0;
  logic prev_hi = 0, prev_lo = 0;
  string tag = "R8";

  function automatic int exp_limit(int w);
    if (w <= DMAX) return w;
    return DMAX;
  endfunction

  function automatic bit exp_upper(int c, int d, bit on);
    if (!on || c < DT) return 0;
    return c < d;
  endfunction

  function automatic bit exp_lower(int c, int d, bit on);
    if (!on) return 0;
    return (c - DT) >= d;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (phase %0d duty %0d)",
               req, what, act, exp, m_cnt, m_duty);
    end
  endtask

  task automatic step();
    bit on, eh, el;
    @(negedge clk);
    on = enable && !force_off;
    eh = exp_upper(m_cnt, m_duty, on);
    el = exp_lower(m_cnt, m_duty, on);
    check(gate_hi === eh && gate_lo === el, on ? tag : "R5", "gates{hi,lo}",
          {gate_hi, gate_lo}, {eh, el});
    check(period_tick === (m_cnt == 0), "R1", "period_tick", period_tick, m_cnt == 0);
    check(!(gate_hi && gate_lo), "R3", "overlap", {gate_hi, gate_lo}, 0);
    if (gate_hi && !prev_hi) check(lo_quiet >= DT, "R4", "lo-to-hi gap", lo_quiet, DT);
    if (gate_lo && !prev_lo) check(hi_quiet >= DT, "R4", "hi-to-lo gap", hi_quiet, DT);
    lo_quiet = gate_lo ? 0 : (lo_quiet < 1000 ? lo_quiet + 1 : lo_quiet);
    hi_quiet = gate_hi ? 0 : (hi_quiet < 1000 ? hi_quiet + 1 : hi_quiet);
    prev_hi = gate_hi;
    prev_lo = gate_lo;
    if (m_cnt == P - 1) m_duty = exp_limit(int'(duty_cmd));
    m_cnt = (m_cnt + 1) % P;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic to_phase(int ph);
    while (m_cnt != ph) step();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd7301);
    // R9: reset state
    repeat (3) begin
      @(negedge clk);
      check(!gate_hi && !gate_lo && !period_tick, "R9", "outputs in reset",
            {gate_hi, gate_lo, period_tick}, 0);
    end
    enable = 1'b1;
    rst_n = 1'b1;

    tag = "R7"; duty_cmd = '0; steps(2 * P);
    tag = "R8"; to_phase(P - 1); duty_cmd = 10'd300; steps(2 * P);
    to_phase(P - 1); duty_cmd = 10'd3; steps(P + 1);
    to_phase(P - 1); duty_cmd = 10'd5; steps(P + 1);
    tag = "R2"; to_phase(P - 1); duty_cmd = 10'd1023; steps(P + 1);
    to_phase(P - 1); duty_cmd = 10'd600; steps(P + 1);
    to_phase(P - 1); duty_cmd = 10'd599; steps(P + 1);
    tag = "R6"; to_phase(P - 1); duty_cmd = 10'd300; step();
    to_phase(100); duty_cmd = 10'd50; steps(150);
    duty_cmd = 10'd500; to_phase(P - 1); duty_cmd = 10'd200; steps(P + 1);

    // R5 collision: shutdown and duty load on the same last-phase clock
    tag = "R5"; to_phase(P - 1); force_off = 1'b1; duty_cmd = 10'd200; steps(P);
    to_phase(50); force_off = 1'b0; steps(P);
    to_phase(P - 1); enable = 1'b0; steps(300); enable = 1'b1; steps(P);

    tag = "R8";
    for (int k = 0; k < 120; k++) begin
      int r;
      duty_cmd = DW'($urandom_range(0, 1023));
      r = $urandom_range(0, 7);
      enable = (r != 0);
      force_off = (r == 1);
      steps($urandom_range(1, 400));
    end
    enable = 1'b1; force_off = 1'b0;
    steps(P);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule